// File: doc/BRIEF.md
# Burst ROM Line-Fill Controller

This block connects an internal read/write request port to an external parallel ROM that can answer burst reads. A read request fetches one 32-byte line. The beat holding the requested address arrives first. The following beats wrap around inside the line until all 32 bytes have been transferred. The external data path can be 8, 16 or 32 bits wide. The line is split into bursts of a selectable length. Inside a burst, chip select and the read strobe stay asserted and only the address moves. Between bursts the strobe is released for one hold cycle, and a new setup cycle follows. Chip select and the busy flag stay high until the whole line is done.

When the interface type is not the burst code, every beat becomes its own single access. A write is always one single access. Each captured beat is handed to the internal side with a valid strobe, the data and the byte offset within the line. A done pulse marks the final beat of a line, or the end of a write.

The controller walks through these states:
- `ST_IDLE`: accepts a request.
- `ST_SETUP`: drives the address with the strobe off.
- `ST_FIRST`: the first beat of a burst.
- `ST_BEAT`: the later beats of a burst.
- `ST_HOLD`: the strobe is off and the address is still held.
- `ST_WSETUP`, `ST_WSTROBE`, `ST_WHOLD`: the write path.

Transitions:
- IDLE to SETUP on a read request. IDLE to WSETUP on a write request.
- SETUP to FIRST.
- FIRST or BEAT to BEAT when a beat is captured and the burst still has beats left.
- FIRST or BEAT to HOLD on the last beat of a burst.
- HOLD to SETUP when the line has more bursts. HOLD to IDLE after the final burst.
- WSETUP to WSTROBE, WSTROBE to WHOLD once the wait is satisfied, and WHOLD to IDLE.

Top module: `brc_burst_rom_ctrl`

## Requirements
- R1: After reset the following are all low: `rom_cs`, `rom_rd`, `rom_we`, `rom_dout_en`, `busy`, `done` and `rd_valid`.
- R2: A read request produces exactly 32/width-in-bytes `rd_valid` beats. The width code `bus_w` means 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit. Each beat's `rd_data` is the value sampled on `rom_din`, masked to the bus width (low bits).
- R3: The first beat reads the bus word that contains `req_addr`. Beat k reads word index (start + k) mod beats-per-line, where start = `req_addr[4:0]` divided by the width in bytes. `rd_offset` and the low five bits of `rom_addr` equal that index times the width in bytes. The upper address bits come from `req_addr`.
- R4: In burst mode (`if_type` == 3'b010), the burst length is 4 << `bst` beats, so `bst` 0..3 gives 4, 8, 16 or 32 beats. The largest legal code is 3 for an 8-bit bus, 2 for a 16-bit bus and 1 for a 32-bit bus. Larger codes are clamped to that maximum. The line therefore takes (beats per line / burst length) strobe pulses.
- R5: Each burst costs 1 setup cycle, plus `wait_cfg`+1 strobe cycles for the first beat, plus max(`wait_cfg`,1)+1 cycles for every later beat, plus 1 hold cycle. During a burst `rom_rd` and `rom_cs` stay high, and `rom_addr` changes only at a beat capture.
- R6: When `wait_cfg` ≥ 1, a beat completes only in a cycle where `rom_ready` is high. When `wait_cfg` = 0, `rom_ready` has no effect.
- R7: `busy` stays high from acceptance to the end of the line. `done` pulses for one cycle together with the final `rd_valid`. `busy` falls only right after `done`.
- R8: With any other `if_type`, every beat is a separate access with its own setup, strobe and hold, that is, one strobe pulse per beat.
- R9: A write request (`req_we`=1) makes one access: a setup cycle, then `wait_cfg`+1 or more cycles with `rom_we` high, then a hold cycle with `done`. During the access `rom_addr` = `req_addr` and `rom_dout` = `req_wdata`, and `rom_rd` never rises.
- R10: `rom_rd` and `rom_we` are never high together. A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, taken when idle |
| req_we | input | 1 | 1 = write, 0 = line read |
| req_addr | input | ADDR_W | Requested byte address |
| req_wdata | input | 32 | Write data |
| if_type | input | 3 | Interface type, 3'b010 = burst ROM |
| bus_w | input | 2 | Bus width code |
| bst | input | 3 | Burst length code |
| wait_cfg | input | WAIT_W | Wait cycle count |
| rom_ready | input | 1 | External ready |
| rom_din | input | 32 | ROM read data |
| rom_cs | output | 1 | Chip select |
| rom_rd | output | 1 | Read strobe |
| rom_we | output | 1 | Write strobe |
| rom_addr | output | ADDR_W | External address |
| rom_dout | output | 32 | Write data to the bus |
| rom_dout_en | output | 1 | Write data drive enable |
| busy | output | 1 | Bus held by a transfer |
| done | output | 1 | End of line or write |
| rd_valid | output | 1 | Beat data valid |
| rd_data | output | 32 | Beat data |
| rd_offset | output | 5 | Byte offset of the beat in the line |

## Verification
The checker assumes that `bus_w`, `if_type`, `bst` and `wait_cfg` do not change while `busy` is high. Its beat-count property recomputes the beats per line from the live `bus_w` input. The bench changes these settings only between transfers, when `busy` is low. It drives `rom_ready` and the request inputs only on falling edges. Any request raised while busy is withdrawn before the line ends.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
    localparam int BUS_MAX_W  = 32;
    localparam int LINE_OFF_W = 5;
    localparam logic [2:0] TYPE_BURST = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_FIRST, ST_BEAT, ST_HOLD,
        ST_WSETUP, ST_WSTROBE, ST_WHOLD
    } brc_state_e;

    // log2 of the bus width in bytes; code 3 is treated as 32-bit
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction
endpackage

// File: rtl/brc_cfg.sv
`timescale 1ns/1ps
module brc_cfg
    import brc_pkg::*;
(
    input  logic [2:0] if_type,
    input  logic [1:0] bus_w,
    input  logic [2:0] bst,
    output logic [1:0] shift,
    output logic [4:0] line_m1,
    output logic [4:0] burst_m1
);
    logic [2:0] max_code;
    logic [2:0] eff_code;
    logic [5:0] burst_len;

    always_comb begin
        shift     = width_shift(bus_w);
        line_m1   = 5'd31 >> shift;
        max_code  = 3'd3 - {1'b0, shift};
        eff_code  = (bst > max_code) ? max_code : bst;
        burst_len = 6'd4 << eff_code;
        if (if_type == TYPE_BURST) begin
            burst_m1 = 5'(burst_len - 6'd1);
        end else begin
            burst_m1 = 5'd0;
        end
    end
endmodule

// File: rtl/brc_addr_gen.sv
`timescale 1ns/1ps
module brc_addr_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [4:0] start_idx,
    input  logic [4:0] load_mask,
    input  logic       step,
    input  logic [4:0] run_mask,
    input  logic [1:0] shift,
    output logic [4:0] offset
);
    logic [4:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= start_idx & load_mask;
        end else if (step) begin
            idx_q <= (idx_q + 5'd1) & run_mask;
        end
    end

    assign offset = (idx_q & run_mask) << shift;
endmodule

// File: rtl/brc_wait.sv
`timescale 1ns/1ps
module brc_wait #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              min1,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              ready,
    output logic              ok
);
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] need;

    always_comb begin
        need = (min1 && wait_cfg == '0) ? WAIT_W'(1) : wait_cfg;
        ok   = active && (cnt_q >= need) && ((wait_cfg == '0) || ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || ok) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + WAIT_W'(1);
        end
    end
endmodule

// File: rtl/brc_burst_rom_ctrl.sv
`timescale 1ns/1ps
module brc_burst_rom_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_MAX_W-1:0] req_wdata,
    input  logic [2:0]           if_type,
    input  logic [1:0]           bus_w,
    input  logic [2:0]           bst,
    input  logic [WAIT_W-1:0]    wait_cfg,
    input  logic                 rom_ready,
    input  logic [BUS_MAX_W-1:0] rom_din,
    output logic                 rom_cs,
    output logic                 rom_rd,
    output logic                 rom_we,
    output logic [ADDR_W-1:0]    rom_addr,
    output logic [BUS_MAX_W-1:0] rom_dout,
    output logic                 rom_dout_en,
    output logic                 busy,
    output logic                 done,
    output logic                 rd_valid,
    output logic [BUS_MAX_W-1:0] rd_data,
    output logic [4:0]           rd_offset
);
    localparam int BASE_W = ADDR_W - LINE_OFF_W;

    brc_state_e state_q, state_d;

    logic [1:0]           cfg_shift, shift_q;
    logic [4:0]           cfg_line_m1, line_m1_q;
    logic [4:0]           cfg_burst_m1, burst_m1_q;
    logic [WAIT_W-1:0]    wait_q;
    logic [BASE_W-1:0]    base_q;
    logic [ADDR_W-1:0]    waddr_q;
    logic [BUS_MAX_W-1:0] wdata_q;
    logic [4:0]           beat_cnt_q, burst_cnt_q;
    logic                 line_end_q;
    logic                 valid_q;
    logic [BUS_MAX_W-1:0] data_q;
    logic [4:0]           off_q;

    logic       accept, accept_rd, cap, burst_last, step;
    logic       strobe_active, wait_ok;
    logic [4:0] offset;
    logic [BUS_MAX_W-1:0] width_mask;

    brc_cfg i_cfg (
        .if_type (if_type),
        .bus_w   (bus_w),
        .bst     (bst),
        .shift   (cfg_shift),
        .line_m1 (cfg_line_m1),
        .burst_m1(cfg_burst_m1)
    );

    brc_addr_gen i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_rd),
        .start_idx(req_addr[4:0] >> cfg_shift),
        .load_mask(cfg_line_m1),
        .step     (step),
        .run_mask (line_m1_q),
        .shift    (shift_q),
        .offset   (offset)
    );

    brc_wait #(.WAIT_W(WAIT_W)) i_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (strobe_active),
        .min1    (state_q == ST_BEAT),
        .wait_cfg(wait_q),
        .ready   (rom_ready),
        .ok      (wait_ok)
    );

    always_comb begin
        accept        = (state_q == ST_IDLE) && req;
        accept_rd     = accept && !req_we;
        strobe_active = (state_q == ST_FIRST) || (state_q == ST_BEAT) ||
                        (state_q == ST_WSTROBE);
        cap           = wait_ok && ((state_q == ST_FIRST) || (state_q == ST_BEAT));
        burst_last    = (burst_cnt_q == burst_m1_q);
        step          = (cap && !burst_last) || ((state_q == ST_HOLD) && !line_end_q);
        unique case (shift_q)
            2'd0:    width_mask = BUS_MAX_W'(32'h0000_00FF);
            2'd1:    width_mask = BUS_MAX_W'(32'h0000_FFFF);
            default: width_mask = '1;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req) state_d = req_we ? ST_WSETUP : ST_SETUP;
            ST_SETUP:   state_d = ST_FIRST;
            ST_FIRST,
            ST_BEAT:    if (cap) state_d = burst_last ? ST_HOLD : ST_BEAT;
            ST_HOLD:    state_d = line_end_q ? ST_IDLE : ST_SETUP;
            ST_WSETUP:  state_d = ST_WSTROBE;
            ST_WSTROBE: if (wait_ok) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            line_m1_q   <= '0;
            burst_m1_q  <= '0;
            wait_q      <= '0;
            base_q      <= '0;
            waddr_q     <= '0;
            wdata_q     <= '0;
            beat_cnt_q  <= '0;
            burst_cnt_q <= '0;
            line_end_q  <= 1'b0;
            valid_q     <= 1'b0;
            data_q      <= '0;
            off_q       <= '0;
        end else begin
            valid_q <= cap;
            if (accept) begin
                shift_q    <= cfg_shift;
                line_m1_q  <= cfg_line_m1;
                burst_m1_q <= cfg_burst_m1;
                wait_q     <= wait_cfg;
                base_q     <= req_addr[ADDR_W-1:LINE_OFF_W];
                waddr_q    <= req_addr;
                wdata_q    <= req_wdata;
                beat_cnt_q <= '0;
                line_end_q <= 1'b0;
            end
            if (state_q == ST_SETUP) begin
                burst_cnt_q <= '0;
            end
            if (cap) begin
                data_q      <= rom_din & width_mask;
                off_q       <= offset;
                burst_cnt_q <= burst_cnt_q + 5'd1;
                beat_cnt_q  <= beat_cnt_q + 5'd1;
                if (beat_cnt_q == line_m1_q) line_end_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rom_cs      = 1'b0;
        rom_rd      = 1'b0;
        rom_we      = 1'b0;
        rom_dout_en = 1'b0;
        done        = 1'b0;
        rom_addr    = {base_q, offset};
        unique case (state_q)
            ST_IDLE:    ;
            ST_SETUP:   rom_cs = 1'b1;
            ST_FIRST,
            ST_BEAT:    begin rom_cs = 1'b1; rom_rd = 1'b1; end
            ST_HOLD:    begin rom_cs = 1'b1; done = line_end_q; end
            ST_WSETUP:  begin rom_cs = 1'b1; rom_dout_en = 1'b1; rom_addr = waddr_q; end
            ST_WSTROBE: begin rom_cs = 1'b1; rom_dout_en = 1'b1; rom_we = 1'b1; rom_addr = waddr_q; end
            ST_WHOLD:   begin rom_cs = 1'b1; rom_dout_en = 1'b1; done = 1'b1; rom_addr = waddr_q; end
            default:    ;
        endcase
        busy      = (state_q != ST_IDLE);
        rom_dout  = wdata_q;
        rd_valid  = valid_q;
        rd_data   = data_q;
        rd_offset = off_q;
    end
endmodule

// File: rtl/brc_checker.sv
`timescale 1ns/1ps
module brc_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_w,
    input logic              rom_cs,
    input logic              rom_rd,
    input logic              rom_we,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic [4:0]        rd_offset
);
    logic [5:0] vcnt_q;
    logic [5:0] line_beats;

    assign line_beats = 6'd32 >> ((bus_w == 2'd3) ? 2'd2 : bus_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vcnt_q <= '0;
        else if (!busy)    vcnt_q <= '0;
        else if (rd_valid) vcnt_q <= vcnt_q + 6'd1;
    end

    assert_no_rd_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_rd && rom_we));
    assert_strobe_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd || rom_we) |-> rom_cs);
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && $past(rom_rd) && !rd_valid) |-> $stable(rom_addr));
    assert_bus_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
    assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_valid) |-> (vcnt_q + 6'd1 == line_beats));
    assert_offset_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && bus_w == 2'd1) |-> (rd_offset[0] == 1'b0));
endmodule

bind brc_burst_rom_ctrl brc_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_w    (bus_w),
    .rom_cs   (rom_cs),
    .rom_rd   (rom_rd),
    .rom_we   (rom_we),
    .rom_addr (rom_addr),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .rd_offset(rd_offset)
);

// File: tb/test_brc_burst_rom_ctrl.sv
`timescale 1ns/1ps
module test_brc_burst_rom_ctrl;
    localparam int ADDR_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  if_type = 3'b010;
    logic [1:0]  bus_w = 2'd0;
    logic [2:0]  bst = 3'd0;
    logic [3:0]  wait_cfg = 4'd0;
    logic        rom_ready = 1'b1;
    logic [31:0] rom_din;
    logic        rom_cs, rom_rd, rom_we, rom_dout_en, busy, done, rd_valid;
    logic [23:0] rom_addr;
    logic [31:0] rom_dout, rd_data;
    logic [4:0]  rd_offset;

    int n_chk = 0, n_err = 0;
    int rd_starts = 0, we_cycles = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA7;
    logic prev_rd = 1'b0;
    logic [4:0]  exp_off[$];
    logic [31:0] exp_dat[$];

    always #2.5 clk = ~clk;

    brc_burst_rom_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(4)) i_brc_burst_rom_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .if_type(if_type), .bus_w(bus_w), .bst(bst),
        .wait_cfg(wait_cfg), .rom_ready(rom_ready), .rom_din(rom_din),
        .rom_cs(rom_cs), .rom_rd(rom_rd), .rom_we(rom_we), .rom_addr(rom_addr),
        .rom_dout(rom_dout), .rom_dout_en(rom_dout_en), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_offset(rd_offset)
    );

    function automatic logic [31:0] romval(input logic [23:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11, ~a[7:0], a[7:0] ^ a[23:16]};
    endfunction

    assign rom_din = romval(rom_addr);

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // ready driver
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rdy_mode == 0)      rom_ready <= 1'b1;
        else if (rdy_mode == 1) rom_ready <= 1'b0;
        else                    rom_ready <= lfsr[0];
    end

    // monitor: pops scoreboard entries, counts strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (rom_rd && !prev_rd) rd_starts++;
            if (rom_we) we_cycles++;
            if (rd_valid) begin
                if (exp_dat.size() == 0) begin
                    chk("R2 unexpected beat", 32'd1, 32'd0);
                end else begin
                    chk("R2 beat data", rd_data, exp_dat.pop_front());
                    chk("R3 beat offset", {27'd0, rd_offset}, {27'd0, exp_off.pop_front()});
                end
            end
        end
        prev_rd <= rom_rd;
    end

    task automatic do_read(input logic [23:0] a, input logic [1:0] bw, input logic [2:0] b,
                           input logic [2:0] ty, input logic [3:0] w, input int rmode,
                           input logic intrude);
        int sh, L, maxc, eff, B, N, wb, exp_cyc, start, cyc;
        logic [31:0] mask;
        sh   = (bw == 2'd0) ? 0 : (bw == 2'd1) ? 1 : 2;
        L    = 32 >> sh;
        maxc = 3 - sh;
        eff  = (int'(b) > maxc) ? maxc : int'(b);
        B    = (ty == 3'b010) ? (4 << eff) : 1;
        N    = L / B;
        wb   = (w == 0) ? 1 : int'(w);
        exp_cyc = N * (1 + (int'(w) + 1) + (B - 1) * (wb + 1) + 1);
        mask = (sh == 0) ? 32'hFF : (sh == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        start = int'(a[4:0]) >> sh;
        for (int i = 0; i < L; i++) begin
            logic [4:0] off;
            off = 5'(((start + i) % L) << sh);
            exp_off.push_back(off);
            exp_dat.push_back(romval({a[23:5], off}) & mask);
        end
        @(negedge clk);
        bus_w = bw; bst = b; if_type = ty; wait_cfg = w; rdy_mode = rmode;
        req_addr = a; req_we = 1'b0; req = 1'b1;
        rd_starts = 0; we_cycles = 0;
        @(negedge clk);
        req = 1'b0;
        cyc = 0;
        while (1) begin
            if (busy) cyc++;
            if (intrude && cyc == 3) begin req = 1'b1; req_we = 1'b1; end
            if (intrude && cyc == 6) begin req = 1'b0; req_we = 1'b0; end
            if (done || cyc > 4000) break;
            @(negedge clk);
        end
        if (rmode != 2) chk("R5 R6 line cycles", 32'(cyc), 32'(exp_cyc));
        chk("R4 R8 strobe pulses", 32'(rd_starts), 32'(N));
        chk("R7 done with busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R7 busy released", {31'd0, busy}, 32'd0);
        chk("R2 all beats seen", 32'(exp_dat.size()), 32'd0);
        if (intrude) chk("R10 no write during read", 32'(we_cycles), 32'd0);
        rdy_mode = 0;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [31:0] d, input logic [3:0] w);
        int cyc;
        @(negedge clk);
        wait_cfg = w; req_addr = a; req_wdata = d; req_we = 1'b1; req = 1'b1;
        rd_starts = 0; we_cycles = 0;
        @(negedge clk);
        req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        cyc = 0;
        while (1) begin
            if (busy) cyc++;
            if (rom_we) begin
                chk("R9 write addr", {8'd0, rom_addr}, {8'd0, a});
                chk("R9 write data", rom_dout, d);
                chk("R9 drive enable", {31'd0, rom_dout_en}, 32'd1);
            end
            if (done || cyc > 100) break;
            @(negedge clk);
        end
        chk("R9 write cycles", 32'(cyc), 32'(int'(w) + 3));
        chk("R9 write strobe width", 32'(we_cycles), 32'(int'(w) + 1));
        @(negedge clk);
        chk("R9 no read strobe", 32'(rd_starts), 32'd0);
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cs/rd/we", {29'd0, rom_cs, rom_rd, rom_we}, 32'd0);
        chk("R1 reset busy/done/valid", {28'd0, busy, done, rd_valid, rom_dout_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {31'd0, busy}, 32'd0);

        do_read(24'h12_3457, 2'd2, 3'd1, 3'b010, 4'd0, 0, 1'b0); // 32-bit, 8-beat, mid-line start
        do_read(24'h00_A01D, 2'd1, 3'd0, 3'b010, 4'd0, 0, 1'b0); // 16-bit, 4 bursts of 4
        do_read(24'hFF_FF1F, 2'd0, 3'd3, 3'b010, 4'd2, 0, 1'b0); // 8-bit, 32-beat burst, waits
        do_read(24'h5A_5A03, 2'd0, 3'd7, 3'b010, 4'd0, 1, 1'b0); // R4 clamp, R6 ready ignored
        do_read(24'h01_0208, 2'd1, 3'd5, 3'b010, 4'd1, 0, 1'b0); // R4 clamp to 16
        do_read(24'h33_4410, 2'd3, 3'd3, 3'b010, 4'd0, 0, 1'b0); // R4 clamp 32-bit to 8
        do_read(24'h77_0014, 2'd2, 3'd0, 3'b010, 4'd3, 2, 1'b0); // R6 random ready
        do_read(24'h00_0006, 2'd1, 3'd2, 3'b001, 4'd1, 0, 1'b0); // R8 single accesses
        do_read(24'h0A_0B0C, 2'd2, 3'd1, 3'b010, 4'd1, 0, 1'b1); // R10 request while busy
        do_write(24'h45_6789, 32'hDEAD_BEEF, 4'd0);
        do_write(24'h01_2345, 32'h1357_9BDF, 4'd4);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule